// File: doc/BRIEF.md
# Reloadable Prescaled Down-Counter Channel

This block is a single timer channel. A 32-bit count decrements by one on every tick of an internal prescaler, which divides the block clock by 4, 16, 64, 256 or 1024. When a tick arrives and the count is already zero, the count reloads from a reload-constant register and a sticky underflow flag is set. The flag, gated by an enable bit, drives the interrupt line.

Software accesses four 32-bit registers through a word-addressed port, with byte address bits [3:2] selecting the register. The registers are the reload constant (0), the count (1), the control word (2) and a plain storage register (3) that is present only when the `HAS_STORE` parameter is set. An external `run` input starts counting and pauses it. Writing the control word restarts the prescaler phase, so a newly chosen divisor always begins with a full period.

Top module: `countdown_channel`

## Requirements
- R1: After reset the reload constant and the count both read 0xFFFFFFFF, the control word and the storage register read 0, and `irq` is low.
- R2: Byte address bits [3:2] select the register: 0 is the reload constant, 1 the count, 2 the control word and 3 the storage register. A write takes effect at the clock edge, and a read returns the value combinationally. With `HAS_STORE` at 0, offset 3 reads 0.
- R3: Control bits [2:0] select the divisor. Codes 0, 1, 2, 3 and 4 give D = 4, 16, 64, 256 and 1024. While `run` is high, counted from the last control write, the count steps once at the D-th run cycle and then once every D run cycles.
- R4: Control codes 5, 6 and 7 produce no ticks, so the count never changes.
- R5: While `run` is low, neither the count nor the prescaler phase advances.
- R6: A tick with the count at zero loads the reload constant and sets the underflow flag in the same cycle. A tick at any other count decrements the count by one.
- R7: A control write with bit 8 at 0 clears the underflow flag. A control write with bit 8 at 1 leaves the flag unchanged and never sets it.
- R8: `irq` is high exactly when the underflow flag is set and control bit 5 is 1.
- R9: A control read returns stored bits [7:0] in bits [7:0] and the underflow flag in bit 8. Bits [31:9] read as 0.
- R10: A count write in the same cycle as a tick wins: the count takes the written value, and that tick neither decrements, reloads nor sets the flag.
- R11: A control write restarts the prescaler phase, and the cycle of that write produces no tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the prescaler input |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | Counting enable from outside; low pauses |
| addr | input | 4 | Byte address; bits [3:2] select the register |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for the register at `addr` |
| irq | output | 1 | Underflow flag ANDed with the interrupt enable |

## Verification
The bench sweeps every valid divisor code and checks the count one run cycle before the first tick, at the first tick and two periods later. A prescaler that is off by one, ignores the code or keeps stepping while paused therefore shows a wrong count. It forces a count write onto the exact cycle of a tick, which separates a design that lets the tick win (count one below the written value) from a correct one. It also interrupts a period with a control write: a prescaler that keeps its old phase would tick early. Finally it walks the flag through underflow, a write of one and a write of zero, which exposes a flag that a write of one could set, a flag that fails to clear, and an interrupt that ignores its enable.

// File: rtl/cdc_timer_pkg.sv
// Package: shared constants for the countdown channel.
// Holds the register offsets, the control bit positions and the number of
// valid divisor codes. The bus port and the bench rely on these values.
package cdc_timer_pkg;
    localparam int DATA_W    = 32;
    localparam int NUM_DIV   = 5;            // valid divisor codes 0..NUM_DIV-1
    localparam int CODE_W    = 3;            // width of the divisor select field
    localparam int PRE_W     = 2 * NUM_DIV;  // prescaler width: largest divisor 4^NUM_DIV
    localparam int IE_BIT    = 5;            // interrupt enable position
    localparam int FLAG_BIT  = 8;            // underflow flag position
    localparam int STORE_W   = 8;            // control bits [7:0] are stored

    typedef enum logic [1:0] {
        SEL_RELOAD = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_STORE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/cdc_prescaler.sv
// Module: cdc_prescaler
// Divides the clock by 4^(code+1) and emits a one-cycle tick.
// Assumes: it advances only while run is high, and restart (a control write)
// zeroes the phase and suppresses the tick of its own cycle. Codes at or
// above NUM_DIV never tick.
module cdc_prescaler
    import cdc_timer_pkg::*;
#(
    parameter int NDIV = NUM_DIV
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int PW = 2 * NDIV;

    logic [PW-1:0] phase_q;
    logic [PW-1:0] mask_tbl [NDIV];
    logic [PW-1:0] mask;
    logic          code_ok;

    // Build the terminal-count mask for each valid code.
    for (genvar g = 0; g < NDIV; g++) begin : g_mask
        assign mask_tbl[g] = PW'((64'd1 << (2 * g + 2)) - 64'd1);
    end

    // Select the mask for the current code and flag reserved codes.
    always_comb begin
        mask    = '0;
        code_ok = 1'b0;
        for (int i = 0; i < NDIV; i++) begin
            if (int'(code) == i) begin
                mask    = mask_tbl[i];
                code_ok = 1'b1;
            end
        end
    end

    // The tick fires on the last phase of each period while running.
    assign tick = run && !restart && code_ok && ((phase_q & mask) == mask);

    // Advance the phase while running, or zero it on restart.
    always_ff @(posedge clk) begin
        if (!rst_n)       phase_q <= '0;
        else if (restart) phase_q <= '0;
        else if (run)     phase_q <= phase_q + 1'b1;
    end

    // R11
    restart_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick);

    // R5
    paused_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> $stable(phase_q));
endmodule

// File: rtl/cdc_counter.sv
// Module: cdc_counter
// The count register and the sticky underflow flag.
// Assumes: tick never comes in the same cycle as flag_clr. The top gates
// both from the control write, so the order of the flag updates is free.
module cdc_counter
    import cdc_timer_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         cnt_wr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] reload,
    input  logic         flag_clr,
    output logic [W-1:0] cnt,
    output logic         flag
);
    logic underflow;

    // An underflow is a tick with the count at zero and no software write.
    assign underflow = tick && !cnt_wr && (cnt == '0);

    // Software write first, then reload on underflow, else decrement on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '1;
        else if (cnt_wr)    cnt <= wdata;
        else if (underflow) cnt <= reload;
        else if (tick)      cnt <= cnt - 1'b1;
    end

    // The sticky flag is set by an underflow and cleared only by software.
    always_ff @(posedge clk) begin
        if (!rst_n)         flag <= 1'b0;
        else if (flag_clr)  flag <= 1'b0;
        else if (underflow) flag <= 1'b1;
    end

    // R10
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(wdata)));

    // R6
    reload_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && cnt == '0) |=> (flag && cnt == $past(reload)));

    // R6
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(cnt));

    // R7
    flag_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !tick) |=> !flag);
endmodule

// File: rtl/countdown_channel.sv
// Module: countdown_channel (top)
// A single reloadable down-counter with a word-addressed register port.
// Assumes: one write per cycle on wr_en, with addr[3:2] selecting the register
// and addr[1:0] ignored. Reads are combinational.
module countdown_channel
    import cdc_timer_pkg::*;
#(
    parameter bit HAS_STORE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [3:0]        addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    reg_sel_e            sel;
    logic                wr_reload, wr_count, wr_ctrl, wr_store;
    logic [DATA_W-1:0]   reload_q;
    logic [STORE_W-1:0]  ctrl_q;
    logic [DATA_W-1:0]   store_val;
    logic [DATA_W-1:0]   cnt;
    logic                flag;
    logic                tick;
    logic                flag_clr;

    // Decode the register select and the per-register write strobes.
    assign sel       = reg_sel_e'(addr[3:2]);
    assign wr_reload = wr_en && (sel == SEL_RELOAD);
    assign wr_count  = wr_en && (sel == SEL_COUNT);
    assign wr_ctrl   = wr_en && (sel == SEL_CTRL);
    assign wr_store  = wr_en && (sel == SEL_STORE);
    assign flag_clr  = wr_ctrl && !wr_data[FLAG_BIT];

    // Hold the reload constant.
    always_ff @(posedge clk) begin
        if (!rst_n)         reload_q <= '1;
        else if (wr_reload) reload_q <= wr_data;
    end

    // Hold the stored control bits; bit 8 and above are not stored here.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= wr_data[STORE_W-1:0];
    end

    // The optional plain storage register.
    if (HAS_STORE) begin : g_store
        logic [DATA_W-1:0] store_q;
        // Keep the value written at offset 3.
        always_ff @(posedge clk) begin
            if (!rst_n)        store_q <= '0;
            else if (wr_store) store_q <= wr_data;
        end
        assign store_val = store_q;
    end else begin : g_no_store
        assign store_val = '0;
    end

    cdc_prescaler #(.NDIV(NUM_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (wr_ctrl),
        .code    (ctrl_q[CODE_W-1:0]),
        .tick    (tick)
    );

    cdc_counter #(.W(DATA_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cnt_wr   (wr_count),
        .wdata    (wr_data),
        .reload   (reload_q),
        .flag_clr (flag_clr),
        .cnt      (cnt),
        .flag     (flag)
    );

    // Read mux; the control word carries the live flag in bit 8.
    always_comb begin
        unique case (sel)
            SEL_RELOAD: rd_data = reload_q;
            SEL_COUNT:  rd_data = cnt;
            SEL_CTRL:   rd_data = {{(DATA_W-FLAG_BIT-1){1'b0}}, flag, ctrl_q};
            default:    rd_data = store_val;
        endcase
    end

    // The interrupt is the flag gated by the enable bit.
    assign irq = flag && ctrl_q[IE_BIT];

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wr_data[FLAG_BIT]) |=> !flag);

    // R7
    flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wr_data[FLAG_BIT]) |=> (flag == $past(flag)));

    // R8
    irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wr_data[IE_BIT]) |=> !irq);
endmodule

// File: tb/test_countdown_channel.sv
// Bench: sweeps the divisor codes and the flag and priority corner cases,
// with expected values computed from the requirements.
module test_countdown_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    countdown_channel #(.HAS_STORE(1'b1)) i_countdown_channel (
        .clk(clk), .rst_n(rst_n), .run(run), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input int off, input logic [31:0] d);
        @(negedge clk);
        addr = 4'(off << 2); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int off, output logic [31:0] d);
        @(negedge clk);
        addr = 4'(off << 2);
        #1 d = rd_data;
    endtask

    task automatic run_for(input int n);
        @(negedge clk);
        run = 1'b1;
        repeat (n) @(negedge clk);
        run = 1'b0;
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(0, v); check("R1 reload", v, 32'hFFFF_FFFF);
        rd(1, v); check("R1 count", v, 32'hFFFF_FFFF);
        rd(2, v); check("R1 ctrl", v, 32'h0);
        rd(3, v); check("R1 store", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2 register map
        wr(0, 32'h1234_5678); rd(0, v); check("R2 reload", v, 32'h1234_5678);
        wr(3, 32'hA5A5_0F0F); rd(3, v); check("R2 store", v, 32'hA5A5_0F0F);
        wr(1, 32'h0BAD_F00D); rd(1, v); check("R2 count", v, 32'h0BAD_F00D);
        rd(0, v); check("R2 reload kept", v, 32'h1234_5678);

        // R9 control read masks; code 7 (R4) then produces no ticks
        wr(2, 32'hFFFF_FEFF); rd(2, v); check("R9 ctrl mask", v, 32'h0000_00FF);
        wr(1, 32'd500); run_for(200); rd(1, v); check("R4 code7 hold", v, 32'd500);
        wr(2, 32'h5); run_for(200); rd(1, v); check("R4 code5 hold", v, 32'd500);

        // R3 divisor sweep for every valid code
        for (int c = 0; c < 5; c++) begin
            d = 4 << (2 * c);
            wr(1, 32'd1000); wr(2, 32'(c));
            run_for(d - 1); rd(1, v); check($sformatf("R3 code%0d before", c), v, 32'd1000);
            run_for(1);     rd(1, v); check($sformatf("R3 code%0d first", c), v, 32'd999);
            run_for(2 * d); rd(1, v); check($sformatf("R3 code%0d period", c), v, 32'd997);
            repeat (20) @(negedge clk);
            rd(1, v); check($sformatf("R5 code%0d paused", c), v, 32'd997);
        end

        // R11 control write restarts the phase
        wr(1, 32'd100); wr(2, 32'h0);
        run_for(2); wr(2, 32'h0);
        run_for(3); rd(1, v); check("R11 no early tick", v, 32'd100);
        run_for(1); rd(1, v); check("R11 full period", v, 32'd99);

        // R10 count write collides with a tick
        wr(2, 32'h0);
        @(negedge clk); run = 1'b1;
        repeat (3) @(negedge clk);
        addr = 4'(1 << 2); wr_data = 32'd4242; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; run = 1'b0;
        rd(1, v); check("R10 write wins", v, 32'd4242);
        rd(2, v); check("R10 no flag", v, 32'h0);

        // R6 underflow reload and flag
        wr(0, 32'd7); wr(1, 32'd1); wr(2, 32'h0);
        run_for(4); rd(1, v); check("R6 step to zero", v, 32'd0);
        rd(2, v); check("R6 flag not yet", v, 32'h0);
        run_for(4); rd(1, v); check("R6 reload", v, 32'd7);
        rd(2, v); check("R6 flag set", v, 32'h100);
        check("R8 irq disabled", {31'b0, irq}, 32'h0);

        // R7/R8 flag writes and enable gating
        wr(2, 32'h120); rd(2, v); check("R7 write one keeps", v, 32'h120);
        check("R8 irq on", {31'b0, irq}, 32'h1);
        wr(2, 32'h020); rd(2, v); check("R7 write zero clears", v, 32'h020);
        check("R8 irq off", {31'b0, irq}, 32'h0);
        wr(2, 32'h120); rd(2, v); check("R7 write one no set", v, 32'h020);
        check("R8 irq stays off", {31'b0, irq}, 32'h0);

        // R6 full wrap from the reload value with the interrupt enabled
        run_for(4 * 7); rd(1, v); check("R6 wrap zero", v, 32'd0);
        check("R8 before wrap", {31'b0, irq}, 32'h0);
        run_for(4); rd(1, v); check("R6 wrap reload", v, 32'd7);
        check("R8 irq after wrap", {31'b0, irq}, 32'h1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule